// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands at a selectable width of one byte, two bytes or four bytes, and derives six status flags from the outcome. The six flags are unsigned carry/borrow, low-byte parity, nibble auxiliary carry, zero, sign and signed overflow. All of them are resolved at the chosen width: operand bits above that width play no part, and result bits above it read as zero. The datapath is purely combinational, so the result and the flags follow the inputs within the same cycle.

A small registered stage sits next to the datapath. It holds a six-bit status word and loads the current flags at any rising clock edge where the capture input is high. An execution stage can therefore keep the flags of the last flag-writing operation while the arithmetic inputs go on changing.

The lane width is a parameter, with a byte of 8 bits by default. A second parameter selects the carry-chain style: an explicit per-bit ripple chain, or a single wide adder whose internal carries are recovered from the sum.

Top module: `arith_flag_unit`

## Requirements
- R1: `width_sel` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 select 32 bits. Result bits above the selected width are 0, and operand bits above it have no effect on any output.
- R2: With `sub_sel`=0 the result is A+B+`carry_in` modulo 2^width. With `sub_sel`=1 it is A−B−`carry_in` modulo 2^width, so `carry_in` acts as a borrow-in.
- R3: `flag_c` is the carry out of the top bit of the selected width on addition. On subtraction it is the borrow, which is 1 when A < B+`carry_in` as unsigned values.
- R4: `flag_p` is 1 when the low 8 bits of the result contain an even number of ones, and 0 otherwise, at every width.
- R5: `flag_a` is 1 when a carry (on addition) or a borrow (on subtraction) passes from bit 3 into bit 4.
- R6: `flag_z` is 1 exactly when the result at the selected width is zero.
- R7: `flag_s` equals the result bit at position width−1.
- R8: `flag_o` is 1 when the signed two's-complement value of the operation lies outside the range of the selected width. It does not depend on `flag_c`.
- R9: `status_q` resets to 0. At a rising edge with `capture`=1 it loads the flags packed as {O,S,Z,A,P,C} in bits 5..0. With `capture`=0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset of the status register |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| carry_in | input | 1 | Carry-in on add, borrow-in on subtract |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| width_sel | input | 2 | Operation width code |
| capture | input | 1 | Load the flags into the status register at the next rising edge |
| result | output | 32 | Masked arithmetic result |
| flag_c | output | 1 | Carry / borrow |
| flag_p | output | 1 | Even parity of the low byte |
| flag_a | output | 1 | Nibble auxiliary carry / borrow |
| flag_z | output | 1 | Zero result |
| flag_s | output | 1 | Sign bit of the result |
| flag_o | output | 1 | Signed overflow |
| status_q | output | 6 | Captured flags {O,S,Z,A,P,C} |

## Verification
The result and the six flags are due in the same cycle as their inputs. The bench drives the inputs on the falling edge and compares the outputs 1 ns after the following rising edge, when they have settled and the inputs are not changing. `status_q` is due at the first rising edge after a cycle with `capture` high. The same sample point therefore sees the newly captured word, or the held word after a cycle with `capture` low. Each scoreboard entry pairs both expectations with the drive cycle that produced them, so one pop per rising edge keeps the two timings aligned.

// File: rtl/afg_pkg.sv
package afg_pkg;

   typedef enum logic [1:0] {
      WSEL_BYTE  = 2'b00,
      WSEL_WORD  = 2'b01,
      WSEL_DWORD = 2'b10,
      WSEL_DWALT = 2'b11
   } wsel_e;

   // packed so that bit 5 is overflow and bit 0 is carry
   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zer;
      logic aux;
      logic par;
      logic cry;
   } flags_t;

   localparam int FLAG_COUNT = 6;

endpackage

// File: rtl/afg_operand_prep.sv
module afg_operand_prep #(
   parameter int BYTE_W = 8
) (
   input  logic [4*BYTE_W-1:0] op_a,
   input  logic [4*BYTE_W-1:0] op_b,
   input  logic                carry_in,
   input  logic                sub_sel,
   input  logic [1:0]          width_sel,
   output logic [4*BYTE_W-1:0] lane_mask,
   output logic [4*BYTE_W-1:0] x_eff,
   output logic [4*BYTE_W-1:0] y_eff,
   output logic                cin_eff
);
   localparam int DW = 4 * BYTE_W;
   localparam int WW = 2 * BYTE_W;

   always_comb begin
      case (width_sel)
         afg_pkg::WSEL_BYTE: lane_mask = {{(DW - BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
         afg_pkg::WSEL_WORD: lane_mask = {{(DW - WW){1'b0}}, {WW{1'b1}}};
         default:            lane_mask = {DW{1'b1}};
      endcase
   end

   // subtraction is A + ~B + ~borrow, with B inverted only inside the lane
   always_comb begin
      x_eff   = op_a & lane_mask;
      y_eff   = (sub_sel ? ~op_b : op_b) & lane_mask;
      cin_eff = carry_in ^ sub_sel;
   end

endmodule

// File: rtl/afg_carry_chain.sv
module afg_carry_chain #(
   parameter int DW          = 32,
   parameter int CARRY_STYLE = 0
) (
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] y,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic [DW:0]   carry
);
   // carry[i] is the carry into bit i, carry[DW] the final carry out
   generate
      if (CARRY_STYLE == 0) begin : g_ripple
         assign carry[0] = cin;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ carry[i];
            assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
         end
      end else begin : g_wide
         logic [DW:0] wide;
         assign wide      = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
         assign sum       = wide[DW-1:0];
         assign carry[DW] = wide[DW];
         for (genvar i = 0; i < DW; i++) begin : g_rec
            assign carry[i] = x[i] ^ y[i] ^ wide[i];
         end
      end
   endgenerate

endmodule

// File: rtl/afg_flag_logic.sv
module afg_flag_logic #(
   parameter int BYTE_W = 8
) (
   input  logic [4*BYTE_W-1:0] sum,
   input  logic [4*BYTE_W:0]   carry,
   input  logic [4*BYTE_W-1:0] lane_mask,
   input  logic                sub_sel,
   input  logic [1:0]          width_sel,
   output logic [4*BYTE_W-1:0] result,
   output afg_pkg::flags_t     flags
);
   localparam int DW      = 4 * BYTE_W;
   localparam int WW      = 2 * BYTE_W;
   localparam int NIB_BIT = BYTE_W / 2;

   logic c_top_out;
   logic c_top_in;
   logic top_bit;

   always_comb begin
      case (width_sel)
         afg_pkg::WSEL_BYTE: begin
            c_top_out = carry[BYTE_W];
            c_top_in  = carry[BYTE_W-1];
            top_bit   = sum[BYTE_W-1];
         end
         afg_pkg::WSEL_WORD: begin
            c_top_out = carry[WW];
            c_top_in  = carry[WW-1];
            top_bit   = sum[WW-1];
         end
         default: begin
            c_top_out = carry[DW];
            c_top_in  = carry[DW-1];
            top_bit   = sum[DW-1];
         end
      endcase
   end

   always_comb begin
      result    = sum & lane_mask;
      flags.cry = c_top_out ^ sub_sel;
      flags.par = ~^result[BYTE_W-1:0];
      flags.aux = carry[NIB_BIT] ^ sub_sel;
      flags.zer = ~|result;
      flags.sgn = top_bit;
      flags.ovf = c_top_out ^ c_top_in;
   end

endmodule

// File: rtl/afg_status_reg.sv
module afg_status_reg (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  afg_pkg::flags_t flags_d,
   output afg_pkg::flags_t flags_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (capture) begin
         flags_q <= flags_d;
      end
   end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
   parameter int BYTE_W      = 8,
   parameter int CARRY_STYLE = 0,
   localparam int DW         = 4 * BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          carry_in,
   input  logic          sub_sel,
   input  logic [1:0]    width_sel,
   input  logic          capture,
   output logic [DW-1:0] result,
   output logic          flag_c,
   output logic          flag_p,
   output logic          flag_a,
   output logic          flag_z,
   output logic          flag_s,
   output logic          flag_o,
   output logic [5:0]    status_q
);
   generate
      if (BYTE_W < 4 || (BYTE_W % 2) != 0) begin : g_bad_byte
         $error("arith_flag_unit: BYTE_W must be even and at least 4");
      end
      if (CARRY_STYLE != 0 && CARRY_STYLE != 1) begin : g_bad_style
         $error("arith_flag_unit: CARRY_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DW-1:0]   lane_mask;
   logic [DW-1:0]   x_eff;
   logic [DW-1:0]   y_eff;
   logic            cin_eff;
   logic [DW-1:0]   sum;
   logic [DW:0]     carry;
   afg_pkg::flags_t flags_now;
   afg_pkg::flags_t flags_held;

   afg_operand_prep #(.BYTE_W(BYTE_W)) u_prep (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sub_sel   (sub_sel),
      .width_sel (width_sel),
      .lane_mask (lane_mask),
      .x_eff     (x_eff),
      .y_eff     (y_eff),
      .cin_eff   (cin_eff)
   );

   afg_carry_chain #(.DW(DW), .CARRY_STYLE(CARRY_STYLE)) u_chain (
      .x     (x_eff),
      .y     (y_eff),
      .cin   (cin_eff),
      .sum   (sum),
      .carry (carry)
   );

   afg_flag_logic #(.BYTE_W(BYTE_W)) u_flags (
      .sum       (sum),
      .carry     (carry),
      .lane_mask (lane_mask),
      .sub_sel   (sub_sel),
      .width_sel (width_sel),
      .result    (result),
      .flags     (flags_now)
   );

   afg_status_reg u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .flags_d (flags_now),
      .flags_q (flags_held)
   );

   assign flag_c   = flags_now.cry;
   assign flag_p   = flags_now.par;
   assign flag_a   = flags_now.aux;
   assign flag_z   = flags_now.zer;
   assign flag_s   = flags_now.sgn;
   assign flag_o   = flags_now.ovf;
   assign status_q = flags_held;

endmodule

// File: rtl/afg_checker.sv
module afg_checker #(
   parameter int BYTE_W = 8,
   localparam int DW    = 4 * BYTE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] op_a,
   input logic [DW-1:0] op_b,
   input logic          carry_in,
   input logic          sub_sel,
   input logic [1:0]    width_sel,
   input logic          capture,
   input logic [DW-1:0] result,
   input logic          flag_c,
   input logic          flag_p,
   input logic          flag_a,
   input logic          flag_z,
   input logic          flag_s,
   input logic          flag_o,
   input logic [5:0]    status_q
);
   logic [BYTE_W:0] byte_sum;
   logic            byte_borrow;
   logic            sel_msb;
   logic            byte_add;

   always_comb begin
      byte_sum    = {1'b0, op_a[BYTE_W-1:0]} + {1'b0, op_b[BYTE_W-1:0]}
                  + {{BYTE_W{1'b0}}, carry_in};
      byte_borrow = ({1'b0, op_a[BYTE_W-1:0]}) <
                    ({1'b0, op_b[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, carry_in});
      byte_add    = (width_sel == 2'b00) && !sub_sel;
      case (width_sel)
         2'b00:   sel_msb = result[BYTE_W-1];
         2'b01:   sel_msb = result[2*BYTE_W-1];
         default: sel_msb = result[DW-1];
      endcase
   end

   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (width_sel == 2'b00) |-> (result[DW-1:BYTE_W] == '0));

   assert_byte_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_add |-> ({flag_c, result[BYTE_W-1:0]} == byte_sum));

   assert_byte_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((width_sel == 2'b00) && sub_sel) |-> (flag_c == byte_borrow));

   assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flag_p == ~^result[BYTE_W-1:0]);

   assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z == (result == '0));

   assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_s == sel_msb);

   assert_byte_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_add |-> (flag_o == ((op_a[BYTE_W-1] == op_b[BYTE_W-1]) &&
                               (result[BYTE_W-1] != op_a[BYTE_W-1]))));

   assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (status_q == $past({flag_o, flag_s, flag_z, flag_a, flag_p, flag_c})));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(status_q));

endmodule

bind arith_flag_unit afg_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sub_sel   (sub_sel),
   .width_sel (width_sel),
   .capture   (capture),
   .result    (result),
   .flag_c    (flag_c),
   .flag_p    (flag_p),
   .flag_a    (flag_a),
   .flag_z    (flag_z),
   .flag_s    (flag_s),
   .flag_o    (flag_o),
   .status_q  (status_q)
);

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic        sub_sel = 1'b0;
   logic [1:0]  width_sel = 2'b00;
   logic        capture = 1'b0;
   logic [31:0] result;
   logic        flag_c, flag_p, flag_a, flag_z, flag_s, flag_o;
   logic [5:0]  status_q;

   always #2 clk = ~clk;

   arith_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .sub_sel(sub_sel), .width_sel(width_sel), .capture(capture),
      .result(result), .flag_c(flag_c), .flag_p(flag_p), .flag_a(flag_a),
      .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .status_q(status_q)
   );

   typedef struct packed {
      logic [31:0] res;
      logic [5:0]  fl;
      logic [5:0]  st;
   } exp_t;

   exp_t       sb_q[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   logic [5:0] st_model = '0;
   bit         done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // independent model of the requirements: flags packed {O,S,Z,A,P,C}
   function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                  input logic cin, input logic sub, input logic [1:0] ws,
                                  input logic cap, input logic [5:0] st_prev);
      exp_t e;
      int w;
      longint unsigned m, ua, ub, r, ci;
      longint sa, sb, s, maxv;
      logic cy, ax, ov;
      w  = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
      m  = (64'd1 << w) - 1;
      ua = {32'd0, a} & m;
      ub = {32'd0, b} & m;
      ci = {63'd0, cin};
      if (!sub) begin
         r  = ua + ub + ci;
         cy = ((r >> w) & 1) != 0;
         ax = ((ua & 15) + (ub & 15) + ci) > 15;
      end else begin
         r  = ua - ub - ci;
         cy = ua < (ub + ci);
         ax = (ua & 15) < ((ub & 15) + ci);
      end
      r  = r & m;
      sa = longint'(ua);
      sb = longint'(ub);
      if (((ua >> (w - 1)) & 1) != 0) sa = sa - (longint'(1) << w);
      if (((ub >> (w - 1)) & 1) != 0) sb = sb - (longint'(1) << w);
      s    = sub ? (sa - sb - longint'(ci)) : (sa + sb + longint'(ci));
      maxv = (longint'(1) << (w - 1)) - 1;
      ov   = (s > maxv) || (s < -maxv - 1);
      e.res = r[31:0];
      e.fl  = {ov, r[w-1], (r == 0), ax, ~^r[7:0], cy};
      e.st  = cap ? e.fl : st_prev;
      return e;
   endfunction

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic cin,
                        input logic sub, input logic [1:0] ws, input logic cap);
      exp_t e;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = cin; sub_sel = sub; width_sel = ws; capture = cap;
      e = model(a, b, cin, sub, ws, cap, st_model);
      st_model = e.st;
      sb_q.push_back(e);
   endtask

   // monitor: combinational outputs are current, status reflects this edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R1/R2 result", result, e.res);
            chk("R3 carry", {31'd0, flag_c}, {31'd0, e.fl[0]});
            chk("R4 parity", {31'd0, flag_p}, {31'd0, e.fl[1]});
            chk("R5 aux", {31'd0, flag_a}, {31'd0, e.fl[2]});
            chk("R6 zero", {31'd0, flag_z}, {31'd0, e.fl[3]});
            chk("R7 sign", {31'd0, flag_s}, {31'd0, e.fl[4]});
            chk("R8 overflow", {31'd0, flag_o}, {31'd0, e.fl[5]});
            chk("R9 status", {26'd0, status_q}, {26'd0, e.st});
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R9 reset status", {26'd0, status_q}, 32'd0);

      // byte: carry, zero, aux, even parity from 0xFF+0x01
      drive(32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b0, 2'b00, 1'b1);
      // byte: signed overflow without carry (R8)
      drive(32'h0000_007F, 32'h0000_0001, 1'b0, 1'b0, 2'b00, 1'b1);
      // byte: overflow with carry-in only
      drive(32'h0000_007F, 32'h0000_0000, 1'b1, 1'b0, 2'b00, 1'b0);
      // byte subtract borrow 0-1 (R3, R5)
      drive(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b00, 1'b1);
      // byte subtract with borrow-in giving zero (R2, R6)
      drive(32'h0000_0005, 32'h0000_0004, 1'b1, 1'b1, 2'b00, 1'b1);
      // upper garbage ignored at byte width (R1)
      drive(32'hDEAD_BE10, 32'h1234_5620, 1'b0, 1'b0, 2'b00, 1'b1);
      drive(32'hFFFF_FF80, 32'hAAAA_AA80, 1'b0, 1'b1, 2'b00, 1'b1);
      // word width
      drive(32'hFFFF_7FFF, 32'h0000_0001, 1'b0, 1'b0, 2'b01, 1'b1);
      drive(32'h0000_FFFF, 32'hFFFF_0001, 1'b0, 1'b0, 2'b01, 1'b1);
      drive(32'h0000_8000, 32'h0000_0001, 1'b0, 1'b1, 2'b01, 1'b1);
      // dword width, both codes (R1)
      drive(32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b10, 1'b1);
      drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b11, 1'b1);
      drive(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 2'b10, 1'b0);
      // hold while capture low (R9)
      drive(32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 2'b00, 1'b0);
      drive(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 2'b10, 1'b0);

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = $urandom;
         if ((i % 7) == 0) a = a | 32'h8080_8080;
         if ((i % 11) == 0) b = ~a;
         drive(a, b, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      end

      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule